// File: doc/BRIEF.md
# Watchdog Timer with Byte-Wide Control Register

This block is a supervisory watchdog for a small processor. Software reaches it through one byte-wide control register on a simple register bus: address, write data, write strobe and read data. The register holds a three-bit period code, an enable bit, a write-only restart bit that clears itself, and a bank-select bit. The bank-select bit drives an output to neighbouring logic and has no other effect here.

Once enabled, the block divides the core clock into a slow time-base tick and counts those ticks. The timeout is a base number of ticks multiplied by two raised to the period code. With the default settings that gives 16 ms for code 0 and 2048 ms for code 7, doubling at each step. Software must write the restart bit before the count runs out. If it does not, the block raises a reset request for a fixed number of clock cycles and then starts a new count at once.

An instruction-cycle strobe input sets when the restart bit falls back to zero. A read shows it as 1 only until the first strobe after the write.

Top module: `wdt_block`

## Requirements
- R1: After reset, a read at the control address returns 0x02: restart bit 1, every other bit 0. `resetReq` and `dpBankSel` are both low.
- R2: The register decodes only at address `REG_ADDR` (0x96). Writes to any other address change nothing, and reads of any other address return 0x00.
- R3: Field layout: bits 7:5 are the period code, bit 2 is the bank select, bit 1 is the restart bit and bit 0 is the enable. Bits 4:3 are reserved. They ignore writes and always read 0.
- R4: `dpBankSel` equals the stored bit 2 from the clock edge that writes it until the next write to the register.
- R5: Writing 1 to bit 1 makes bit 1 read 1. It reads 0 after the first clock edge at which `instrStrobe` is high and no new restart write occurs. Writing 0 to bit 1 leaves it unchanged.
- R6: With enable 1 and no restart, `resetReq` rises exactly `TICK_DIV*BASE_TICKS*2^code` clock edges after the edge that wrote enable from 0 to 1. This holds for every code from 0 to 7.
- R7: `resetReq` stays high for exactly `RST_LEN` cycles. The next rise comes one full period after the previous rise.
- R8: While enable is 0 the count is held at zero and `resetReq` never rises. Setting enable again gives a full period.
- R9: A write with bit 1 set and enable 1 restarts the count. `resetReq` then rises one full period after that write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sfrAddr | input | ADDR_W | Register bus address |
| sfrWrData | input | 8 | Register bus write data |
| sfrWrEn | input | 1 | Write strobe, one cycle per write |
| sfrRdData | output | 8 | Read data for the addressed register, 0 when not addressed |
| instrStrobe | input | 1 | One pulse per instruction cycle; clears the restart bit |
| dpBankSel | output | 1 | Stored bank-select bit |
| resetReq | output | 1 | Reset request, high for RST_LEN cycles on expiry |

## Verification
A divider or tick counter that is off by one shows up as a reset request one or more edges early or late. The bench samples the exact edge at which the request should rise, so any slip is caught on that edge. A field decoded at the wrong bit position appears at once in the read-back value or on `dpBankSel`. A count that a restart or a disable fails to clear shows up as a request well inside the expected period. A restart bit that never clears is caught on the read that follows the first instruction strobe.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  parameter int unsigned PS_W = 3;

  // bit positions inside the control byte
  localparam int unsigned PS_LSB   = 5;
  localparam int unsigned BANK_BIT = 2;
  localparam int unsigned KICK_BIT = 1;
  localparam int unsigned EN_BIT   = 0;

  typedef struct packed {
    logic            enable;
    logic            kick;
    logic [PS_W-1:0] prescale;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h96
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic [7:0]        sfrWrData,
  input  logic              sfrWrEn,
  input  logic              instrStrobe,
  output logic [7:0]        sfrRdData,
  output logic              dpBankSel,
  output wdtStrobe_t        strobes
);
  logic            addrHit;
  logic            wrHit;
  logic            kickWrite;
  logic [PS_W-1:0] psReg;
  logic            bankReg;
  logic            kickBit;
  logic            enReg;

  assign addrHit   = (sfrAddr == REG_ADDR);
  assign wrHit     = addrHit & sfrWrEn;
  assign kickWrite = wrHit & sfrWrData[KICK_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psReg   <= '0;
      bankReg <= 1'b0;
      enReg   <= 1'b0;
    end else if (wrHit) begin
      psReg   <= sfrWrData[PS_LSB +: PS_W];
      bankReg <= sfrWrData[BANK_BIT];
      enReg   <= sfrWrData[EN_BIT];
    end
  end

  // restart bit: set by a write of 1, dropped by the next instruction strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kickBit <= 1'b1;
    end else if (kickWrite) begin
      kickBit <= 1'b1;
    end else if (instrStrobe) begin
      kickBit <= 1'b0;
    end
  end

  always_comb begin
    sfrRdData = '0;
    if (addrHit) begin
      sfrRdData[PS_LSB +: PS_W] = psReg;
      sfrRdData[BANK_BIT]       = bankReg;
      sfrRdData[KICK_BIT]       = kickBit;
      sfrRdData[EN_BIT]         = enReg;
    end
  end

  assign dpBankSel        = bankReg;
  assign strobes.enable   = enReg;
  assign strobes.kick     = kickWrite;
  assign strobes.prescale = psReg;

  AST_KICK_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (kickBit && instrStrobe && !kickWrite) |=> !sfrRdData[KICK_BIT] || !addrHit); // R5
  AST_KICK_SET: assert property (@(posedge clk) disable iff (!rstN)
    kickWrite |=> kickBit); // R5
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrHit |=> $stable(dpBankSel)); // R4
endmodule

// File: rtl/wdt_tick.sv
module wdt_tick #(
  parameter int unsigned TICK_DIV = 12000
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic             atLast;

  assign atLast = (divCnt == DIV_LAST);
  assign tick   = run & ~clear & atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (!run || clear || atLast) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!run || clear) |=> !tick || (TICK_DIV == 1)); // R8
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 16,
  parameter int unsigned RST_LEN    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdtStrobe_t strobes,
  input  logic       tick,
  output logic       resetReq
);
  localparam int unsigned CNT_W = $clog2(BASE_TICKS) + (1 << PS_W);
  localparam int unsigned PL_W  = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] limit;
  logic             expire;
  logic [PL_W-1:0]  pulseCnt;
  logic [PL_W:0]    highRun;

  assign limit  = CNT_W'(BASE_TICKS) << strobes.prescale;
  // ">=" lets a shortened period still expire after a code change
  assign expire = strobes.enable & ~strobes.kick & tick & (tickCnt >= limit - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (!strobes.enable || strobes.kick || expire) begin
      tickCnt <= '0;
    end else if (tick) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (expire) begin
      pulseCnt <= PL_W'(RST_LEN);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign resetReq = (pulseCnt != '0);

  // checker state: consecutive high cycles of the request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highRun <= '0;
    end else if (resetReq) begin
      highRun <= highRun + 1'b1;
    end else begin
      highRun <= '0;
    end
  end

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.enable |=> (tickCnt == '0)); // R8
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.kick |=> (tickCnt == '0)); // R9
  AST_REQ_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> $past(expire)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (tickCnt == '0)); // R6
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (highRun < (PL_W+1)'(RST_LEN))); // R7
endmodule

// File: rtl/wdt_block.sv
module wdt_block
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h96,
  parameter int unsigned TICK_DIV   = 12000,
  parameter int unsigned BASE_TICKS = 16,
  parameter int unsigned RST_LEN    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic [7:0]        sfrWrData,
  input  logic              sfrWrEn,
  output logic [7:0]        sfrRdData,
  input  logic              instrStrobe,
  output logic              dpBankSel,
  output logic              resetReq
);
  wdtStrobe_t strobes;
  logic       tick;

  wdt_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sfrAddr(sfrAddr), .sfrWrData(sfrWrData),
    .sfrWrEn(sfrWrEn), .instrStrobe(instrStrobe), .sfrRdData(sfrRdData),
    .dpBankSel(dpBankSel), .strobes(strobes)
  );

  wdt_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rstN(rstN), .run(strobes.enable), .clear(strobes.kick),
    .tick(tick)
  );

  wdt_count #(.BASE_TICKS(BASE_TICKS), .RST_LEN(RST_LEN)) u_count (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tick(tick),
    .resetReq(resetReq)
  );
endmodule

// File: tb/wdt_block_bench.sv
module wdt_block_bench;
  localparam int unsigned TDIV  = 2;
  localparam int unsigned BASE  = 16;
  localparam int unsigned PLEN  = 4;
  localparam logic [7:0]  RADDR = 8'h96;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] sfrAddr = 8'h00;
  logic [7:0] sfrWrData = 8'h00;
  logic       sfrWrEn = 1'b0;
  logic [7:0] sfrRdData;
  logic       instrStrobe = 1'b0;
  logic       dpBankSel;
  logic       resetReq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  wdt_block #(.ADDR_W(8), .REG_ADDR(RADDR), .TICK_DIV(TDIV),
              .BASE_TICKS(BASE), .RST_LEN(PLEN)) u_wdt_block (
    .clk(clk), .rstN(rstN), .sfrAddr(sfrAddr), .sfrWrData(sfrWrData),
    .sfrWrEn(sfrWrEn), .sfrRdData(sfrRdData), .instrStrobe(instrStrobe),
    .dpBankSel(dpBankSel), .resetReq(resetReq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sfrWrite(logic [7:0] a, logic [7:0] d, logic withStrobe = 1'b0);
    @(negedge clk);
    sfrAddr = a; sfrWrData = d; sfrWrEn = 1'b1; instrStrobe = withStrobe;
    @(posedge clk);
    @(negedge clk);
    sfrWrEn = 1'b0; instrStrobe = 1'b0;
  endtask

  task automatic sfrRead(logic [7:0] a, output logic [7:0] d);
    sfrAddr = a;
    #1;
    d = sfrRdData;
  endtask

  task automatic pulseInstr();
    instrStrobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instrStrobe = 1'b0;
  endtask

  function automatic int periodOf(int code);
    return TDIV * BASE * (1 << code);
  endfunction

  // called just after the negedge following the reference edge
  task automatic expectRise(int edges, string req);
    repeat (edges - 1) @(posedge clk);
    @(negedge clk);
    chk({req, " low one edge before expiry"}, resetReq, 0);
    @(posedge clk);
    @(negedge clk);
    chk({req, " high at expiry edge"}, resetReq, 1);
  endtask

  task automatic expectWidth();
    for (int i = 1; i < PLEN; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R7 request still high", resetReq, 1);
    end
    @(posedge clk); @(negedge clk);
    chk("R7 request dropped after RST_LEN", resetReq, 0);
  endtask

  task automatic testReset();
    logic [7:0] d;
    @(negedge clk);
    sfrRead(RADDR, d);
    chk("R1 reset read value", d, 8'h02);
    chk("R1 reset request low", resetReq, 0);
    chk("R1 reset bank select low", dpBankSel, 0);
    pulseInstr();
    sfrRead(RADDR, d);
    chk("R5 restart bit clears on strobe after reset", d, 8'h00);
  endtask

  task automatic testDecode();
    logic [7:0] d;
    sfrWrite(8'h95, 8'hFF);
    sfrRead(RADDR, d);
    chk("R2 write to other address ignored", d, 8'h00);
    chk("R2 bank select unchanged by miss", dpBankSel, 0);
    sfrRead(8'h95, d);
    chk("R2 other address reads zero", d, 8'h00);
    sfrWrite(8'h97, 8'hE5);
    sfrRead(8'h97, d);
    chk("R2 neighbour address reads zero", d, 8'h00);
  endtask

  task automatic testLayout();
    logic [7:0] d;
    sfrWrite(RADDR, 8'hFE);
    sfrRead(RADDR, d);
    chk("R3 reserved bits read zero", d, 8'hE6);
    chk("R4 bank select follows bit 2", dpBankSel, 1);
    sfrWrite(RADDR, 8'hA0);
    sfrRead(RADDR, d);
    chk("R5 restart bit held until strobe", d, 8'hA2);
    chk("R4 bank select cleared", dpBankSel, 0);
    pulseInstr();
    sfrRead(RADDR, d);
    chk("R3 period field alone", d, 8'hA0);
  endtask

  task automatic testKickBit();
    logic [7:0] d;
    sfrWrite(RADDR, 8'h02, 1'b1);
    sfrRead(RADDR, d);
    chk("R5 write beats strobe in same cycle", d, 8'h02);
    sfrWrite(RADDR, 8'h00);
    sfrRead(RADDR, d);
    chk("R5 writing 0 does not clear", d, 8'h02);
    pulseInstr();
    sfrRead(RADDR, d);
    chk("R5 clears on later strobe", d, 8'h00);
  endtask

  task automatic testPeriods();
    for (int code = 0; code < 8; code++) begin
      sfrWrite(RADDR, 8'h00);
      sfrWrite(RADDR, 8'((code << 5) | 1));
      expectRise(periodOf(code), $sformatf("R6 code %0d", code));
      expectWidth();
    end
    sfrWrite(RADDR, 8'h00);
  endtask

  task automatic testRepeat();
    sfrWrite(RADDR, 8'h21);
    expectRise(periodOf(1), "R6 first expiry");
    expectWidth();
    expectRise(periodOf(1) - PLEN, "R7 second expiry one period later");
    sfrWrite(RADDR, 8'h00);
  endtask

  task automatic testDisable();
    int seen = 0;
    sfrWrite(RADDR, 8'h01);
    repeat (20) @(posedge clk);
    sfrWrite(RADDR, 8'h00);
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); @(negedge clk);
      if (resetReq) seen++;
    end
    chk("R8 no request while disabled", seen, 0);
    sfrWrite(RADDR, 8'h01);
    expectRise(periodOf(0), "R8 full period after re-enable");
    sfrWrite(RADDR, 8'h00);
  endtask

  task automatic testKick();
    sfrWrite(RADDR, 8'h01);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R9 no request before restart", resetReq, 0);
    sfrWrite(RADDR, 8'h03);
    expectRise(periodOf(0), "R9 period counted from restart");
    sfrWrite(RADDR, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDecode();
    testLayout();
    testKickBit();
    testPeriods();
    testRepeat();
    testDisable();
    testKick();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule